// File: doc/BRIEF.md
# Programmable Watchdog Timer

A memory-mapped watchdog for a system-on-chip. Software selects one of sixteen power-of-two timeout lengths, sets the enable bit, and must then keep writing a fixed restart key to a restart register. A down-counter is reloaded by each valid key write. If the counter runs out, the watchdog acts in one of two ways. It can drive a system reset pulse of programmable length at once. Or it can first raise an interrupt and reset only if that interrupt is still pending when the counter runs out a second time.

The register interface is a plain 32-bit bus with a 5-bit byte address, a write strobe and a read strobe. Read data is combinational. Software can read the settings, the live count and the interrupt state. A read strobe at the interrupt-clear offset acknowledges the interrupt. Once enabled, the watchdog stays enabled until the system reset `rst_ni` is applied.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_ni` is released, all settings, the count and the interrupt state read 0, and `irq_o` and `sys_rst_o` are low.
- R2: The register map uses these byte offsets. Offset 0x00 holds the settings: bit 0 is the enable, bit 1 is the response mode, and bits 4:2 are the pulse length code. Offset 0x04 holds the timeout index in bits 3:0. Offset 0x08 returns the live count. Offset 0x0C is the restart register. Offset 0x10 returns the interrupt status in bit 0. Offset 0x14 is the interrupt-clear register. Both 0x0C and 0x14 read as 0.
- R3: Timeout index i gives a counter top of 2^(TOP_BASE+i)-1. The counter is loaded with this top in the cycle that sets the enable bit.
- R4: While enabled, the live count drops by one each clock cycle until it reaches zero.
- R5: The counter expires (top+1) cycles after a load. Expiry reloads the top.
- R6: A write to 0x0C reloads the top only when the watchdog is enabled and bits 7:0 of the write data equal 0x76. Bits 31:8 are not compared. Any other write to 0x0C leaves the count unchanged.
- R7: With the response mode bit at 0, an expiry starts a reset pulse on `sys_rst_o` in the next cycle, and the interrupt stays low.
- R8: With the response mode bit at 1, an expiry while the interrupt is clear sets the interrupt and reloads the counter. An expiry while the interrupt is set starts the reset pulse.
- R9: A read strobe at 0x14 clears the interrupt. A read at 0x10 does not clear it. An expiry in the same cycle as the clear takes priority over the clear.
- R10: A pulse length code n gives a `sys_rst_o` pulse of exactly 2^(n+1) cycles.
- R11: Software cannot clear the enable bit once it is set. Only `rst_ni` clears it.
- R12: An expiry during an active reset pulse neither lengthens nor restarts that pulse.
- R13: While the watchdog is disabled, the count stays at 0 and no interrupt or reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| addr_i | input | 5 | Register byte address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; this strobe is what clears the interrupt at 0x14 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt from a first-stage expiry, active high |
| sys_rst_o | output | 1 | System reset pulse request, active high |

## Verification
The bound assertions check five rules on every cycle:
- the enable bit never falls;
- a valid key reloads the top;
- the count steps down by exactly one;
- a rising reset pulse is always preceded by an expiry;
- the interrupt rises only in interrupt mode and is cleared by the clear strobe.

The exact expiry latency for each timeout index, the exact pulse width for each length code, and the non-retriggering of a running pulse can only be shown by the bench's scenarios. The same holds for the two-stage sequence through interrupt, clear and reset. The bench builds the watchdog with a small base exponent so that these sweeps stay short.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int ADDR_W = 5;
  localparam logic [7:0] RESTART_KEY = 8'h76;

  typedef enum logic [ADDR_W-1:0] {
    OFF_CTRL    = 5'h00,
    OFF_RANGE   = 5'h04,
    OFF_COUNT   = 5'h08,
    OFF_RESTART = 5'h0C,
    OFF_STATUS  = 5'h10,
    OFF_EOI     = 5'h14
  } reg_off_e;
endpackage

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int TOP_BASE = 16,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam int NUM_TOPS = 1 << IDX_W;

  logic [CNT_W-1:0] tops [NUM_TOPS];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_TOPS; g++) begin : g_top
    assign tops[g] = CNT_W'((64'(1) << (TOP_BASE + g)) - 64'(1));
  end

  // a load in the same cycle as zero wins over expiry
  assign expire_o = en_i && (cnt_q == '0) && !load_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i || expire_o)  cnt_q <= tops[idx_i];
    else if (en_i)                cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
`timescale 1ns/1ps
module wdog_rst_pulse #(
  parameter int PULSE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [PULSE_W-1:0] len_i,
  output logic               rst_o
);
  localparam int PCNT_W = 1 << PULSE_W;

  logic              active_q;
  logic [PCNT_W-1:0] cnt_q;
  logic [PULSE_W:0]  sh;

  assign sh    = {1'b0, len_i} + 1'b1;
  assign rst_o = active_q;

  // not retriggerable while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (fire_i) begin
        active_q <= 1'b1;
        cnt_q    <= (PCNT_W'(1) << sh) - PCNT_W'(1);
      end
    end else if (cnt_q == '0) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - PCNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int PULSE_W = 3,
  parameter int CNT_W   = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               irq_set_i,
  output logic               en_o,
  output logic               en_set_o,
  output logic               mode_o,
  output logic [PULSE_W-1:0] len_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               restart_o,
  output logic               irq_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic               en_q, mode_q, irq_q;
  logic [PULSE_W-1:0] len_q;
  logic [IDX_W-1:0]   idx_q;
  logic               wr_ctrl, wr_range, eoi;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:8];

  assign wr_ctrl   = we_i && (addr_i == OFF_CTRL);
  assign wr_range  = we_i && (addr_i == OFF_RANGE);
  assign eoi       = re_i && (addr_i == OFF_EOI);
  assign en_set_o  = wr_ctrl && wdata_i[0] && !en_q;
  assign restart_o = we_i && (addr_i == OFF_RESTART) &&
                     (wdata_i[7:0] == RESTART_KEY) && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= en_q | wdata_i[0];  // sticky
        mode_q <= wdata_i[1];
        len_q  <= wdata_i[2 +: PULSE_W];
      end
      if (wr_range) idx_q <= wdata_i[IDX_W-1:0];
      if (irq_set_i) irq_q <= 1'b1;
      else if (eoi)  irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:   rdata_o = DATA_W'({len_q, mode_q, en_q});
      OFF_RANGE:  rdata_o = DATA_W'(idx_q);
      OFF_COUNT:  rdata_o = DATA_W'(cnt_i);
      OFF_STATUS: rdata_o = DATA_W'(irq_q);
      default:    rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign len_o  = len_q;
  assign idx_o  = idx_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TOP_BASE = 16,
  parameter int IDX_W    = 4,
  parameter int PULSE_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = TOP_BASE + (1 << IDX_W) - 1;

  logic               en_q, en_set, mode_q, restart, expire, fire, irq_set;
  logic [PULSE_W-1:0] len_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   cnt_q;

  assign fire    = expire && (!mode_q || irq_o);
  assign irq_set = expire && mode_q && !irq_o;

  wdog_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PULSE_W(PULSE_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .re_i      (re_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt_q),
    .irq_set_i (irq_set),
    .en_o      (en_q),
    .en_set_o  (en_set),
    .mode_o    (mode_q),
    .len_o     (len_q),
    .idx_o     (idx_q),
    .restart_o (restart),
    .irq_o     (irq_o),
    .rdata_o   (rdata_o)
  );

  wdog_counter #(
    .TOP_BASE(TOP_BASE), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .load_i   (en_set || restart),
    .idx_i    (idx_q),
    .cnt_o    (cnt_q),
    .expire_o (expire)
  );

  wdog_rst_pulse #(
    .PULSE_W(PULSE_W)
  ) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .len_i  (len_q),
    .rst_o  (sys_rst_o)
  );
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int TOP_BASE = 16,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [7:0]        key_i,
  input logic              en_i,
  input logic              mode_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              irq_i,
  input logic              sys_rst_i
);
  logic [CNT_W-1:0] top_c;
  logic             key_hit, at_zero;

  assign top_c   = CNT_W'((64'(1) << (TOP_BASE + int'(idx_i))) - 64'(1));
  assign key_hit = we_i && (addr_i == OFF_RESTART) && (key_i == RESTART_KEY) && en_i;
  assign at_zero = en_i && (cnt_i == '0);

  assert_en_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> en_i);

  assert_restart_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit |=> (cnt_i == $past(top_c)));

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (cnt_i != '0) && !key_hit) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  assert_rst_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_i) |-> $past(at_zero));

  assert_irq_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(mode_i && at_zero));

  assert_eoi_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i == OFF_EOI) && !at_zero) |=> !irq_i);
endmodule

bind wdog_timer wdog_checker #(
  .TOP_BASE(TOP_BASE), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .key_i     (wdata_i[7:0]),
  .en_i      (en_q),
  .mode_i    (mode_q),
  .idx_i     (idx_q),
  .cnt_i     (cnt_q),
  .irq_i     (irq_o),
  .sys_rst_i (sys_rst_o)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int TB_BASE = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, sys_rst_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  wdog_timer #(.TOP_BASE(TB_BASE)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    we_i = 1'b0; re_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rd_strobe(input logic [4:0] a);
    addr_i = a; re_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic wait_sig(input bit sel_irq, input int max, output int k);
    k = 0;
    while (!(sel_irq ? irq_o : sys_rst_o) && k < max) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (sys_rst_o && w < 1000) begin
      @(negedge clk_i);
      w++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k, w, top;
    bit quiet;

    do_reset();
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h08, d); chk("R1 count", d, 0);
    rd(5'h10, d); chk("R1 status", d, 0);
    chk("R1 irq_o", irq_o, 0);
    chk("R1 sys_rst_o", sys_rst_o, 0);

    // disabled: nothing runs, key ignored
    quiet = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_i);
      if (sys_rst_o || irq_o) quiet = 1'b0;
    end
    chk("R13 no output while disabled", quiet, 1);
    wr(5'h0C, 32'h76);
    rd(5'h08, d); chk("R13 R6 key while disabled", d, 0);
    rd(5'h0C, d); chk("R2 restart reads 0", d, 0);

    // every timeout index: top load and live count
    for (int i = 0; i < 16; i++) begin
      do_reset();
      top = (1 << (TB_BASE + i)) - 1;
      wr(5'h04, i);
      rd(5'h04, d); chk("R2 range readback", d, i);
      wr(5'h00, 32'h1);
      rd(5'h08, d); chk("R3 top on enable", d, top);
      repeat (3) @(negedge clk_i);
      rd(5'h08, d); chk("R4 live count", d, top - 3);
    end

    // mode 0 sweep: latency and pulse width
    for (int i = 0; i < 4; i++) begin
      for (int n = 0; n < 8; n++) begin
        do_reset();
        wr(5'h04, i);
        wr(5'h00, (n << 2) | 1);
        if (i == 0) begin
          rd(5'h00, d); chk("R2 ctrl readback", d, (n << 2) | 1);
        end
        wait_sig(1'b0, 5000, k);
        chk("R5 R7 expiry latency", k, 1 << (TB_BASE + i));
        chk("R7 no irq in reset mode", irq_o, 0);
        pulse_width(w);
        chk("R10 R12 pulse width", w, 2 << n);
      end
    end

    // restart key
    do_reset();
    wr(5'h04, 0);
    wr(5'h00, 1);
    repeat (5) @(negedge clk_i);
    wr(5'h0C, 32'h77);
    rd(5'h08, d); chk("R6 wrong key ignored", d, 15 - 6);
    wr(5'h0C, 32'hABCDEF76);
    rd(5'h08, d); chk("R6 key reloads", d, 15);
    wait_sig(1'b0, 5000, k);
    chk("R5 latency after restart", k, 16);

    do_reset();
    wr(5'h00, 1);
    quiet = 1'b1;
    for (int r = 0; r < 20; r++) begin
      for (int c = 0; c < 10; c++) begin
        @(negedge clk_i);
        if (sys_rst_o) quiet = 1'b0;
      end
      wr(5'h0C, 32'h76);
    end
    chk("R6 periodic restart keeps quiet", quiet, 1);

    // sticky enable
    do_reset();
    wr(5'h00, 1);
    wr(5'h00, 0);
    rd(5'h00, d); chk("R11 enable sticky", d[0], 1);
    wait_sig(1'b0, 5000, k);
    chk("R11 still expires", k, 15);

    // two-stage mode
    do_reset();
    wr(5'h00, 3);
    wait_sig(1'b1, 5000, k);
    chk("R8 first expiry irq", k, 16);
    chk("R8 no reset at first expiry", sys_rst_o, 0);
    rd_strobe(5'h10);
    chk("R9 status read keeps irq", irq_o, 1);
    rd(5'h10, d); chk("R2 R9 status bit", d, 1);
    rd_strobe(5'h14);
    chk("R9 clear read", irq_o, 0);
    wait_sig(1'b1, 5000, k);
    chk("R8 reload after first stage", k, 14);
    chk("R8 cleared irq no reset", sys_rst_o, 0);
    wait_sig(1'b0, 5000, k);
    chk("R8 second expiry resets", k, 16);
    chk("R8 irq still pending", irq_o, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule